// File: doc/BRIEF.md
# Touch-Button LED Mode Controller

This block drives four user LEDs from a 3.33 MHz system clock. An LED lights when its output bit is high. After reset the LEDs run a chase: one lit position steps through the four LEDs, and a direction input selects whether it climbs or falls. The first press on any button stops the chase and puts the block in a toggle mode. In that mode every further press flips the LED that belongs to the button. An inactivity timer returns the block to the chase once a full timeout has passed with no press, and every press starts that timeout over.

Button sensing happens elsewhere. This block receives one single-cycle press pulse per button. A separate source-select input lets an external register interface take over the LEDs. The interface supplies four switch bits and four momentary button bits, and the two are combined with XOR, so holding a button inverts its LED for as long as it is held. The toggle state and the four most significant bits of the inactivity timer are exported for monitoring. Step period and timeout are parameters in clock cycles. Their defaults are about a quarter second and five seconds at 3.33 MHz.

Top module: `ledmode_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `ledOut` is 4'b0001 (bit i drives LED i), `toggleState` is 0 and `timerHigh` is 0.
- R2: In chase mode with `scrollDown` low, the lit position moves from LED i to LED i+1 once every STEP_CYCLES clock cycles, and LED 3 wraps to LED 0. The first move comes STEP_CYCLES cycles after reset is released.
- R3: With `scrollDown` high, each step moves the lit position from LED i to LED i-1, and LED 0 wraps to LED 3. The direction is read at the cycle of each step.
- R4: In chase mode, a cycle in which any bit of `pressPulse` is high (bit i is button i) switches the block to toggle mode. That press leaves `toggleState` unchanged. In toggle mode, `ledOut` equals `toggleState`.
- R5: In toggle mode, a press cycle inverts `toggleState[i]` for every set bit i of `pressPulse`, so several buttons pressed in one cycle flip together.
- R6: The inactivity timer is held at 0 in chase mode. In toggle mode it counts up by one per cycle, and every press cycle clears it to 0. `timerHigh` is the timer's four most significant bits.
- R7: TIMEOUT_CYCLES cycles after the last press, the block returns to chase mode. The chase restarts at 4'b0001 with a full step period, and `toggleState` keeps its value.
- R8: A press in the cycle where the timeout would fire takes priority. The block stays in toggle mode, applies the flip and restarts the timer.
- R9: While `selExt` is high, `ledOut[i]` equals `swBits[i] ^ btnBits[i]` in the same cycle. The internal mode logic keeps running, and its state shows on `ledOut` again once `selExt` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pressPulse | input | 4 | One-cycle press pulse per button |
| scrollDown | input | 1 | Chase direction: 1 falls, 0 climbs |
| selExt | input | 1 | 1 hands the LEDs to the external switch/button source |
| swBits | input | 4 | External switch bits |
| btnBits | input | 4 | External momentary button bits |
| ledOut | output | 4 | LED drive, high lights the LED |
| toggleState | output | 4 | Current toggle-mode LED state |
| timerHigh | output | 4 | Upper four bits of the inactivity timer |

## Verification
The press and the timeout expiry can fall in the same cycle. This is the one place where two mode transitions compete. The bench counts cycles from the last press until the timer holds its final value TIMEOUT_CYCLES-1, then pulses a button on exactly the next edge. The result is judged correct if the flip is applied, `timerHigh` reads zero and the LEDs stay in toggle mode for one more full timeout. A return to the chase at that edge would show up on `ledOut` as 4'b0001.

// File: rtl/ledmode_pkg.sv
package ledmode_pkg;

  typedef enum logic {
    MODE_SCROLL = 1'b0,
    MODE_TOGGLE = 1'b1
  } ledMode_e;

  typedef struct packed {
    logic stepScroll;
    logic restartScroll;
    logic applyFlips;
    logic showToggle;
  } ctrlStrobes_t;

endpackage

// File: rtl/ledmode_ctrl.sv
module ledmode_ctrl
  import ledmode_pkg::*;
#(
  parameter int NUM_LEDS       = 4,
  parameter int STEP_CYCLES    = 832_500,
  parameter int TIMEOUT_CYCLES = 16_650_000,
  localparam int TIMER_W       = $clog2(TIMEOUT_CYCLES + 1),
  localparam int STEP_W        = $clog2(STEP_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LEDS-1:0] pressPulse,
  output ctrlStrobes_t        strobes,
  output logic [TIMER_W-1:0]  timerVal,
  output logic                inToggle
);

  localparam logic [STEP_W-1:0]  STEP_LAST    = STEP_W'(STEP_CYCLES - 1);
  localparam logic [TIMER_W-1:0] TIMEOUT_LAST = TIMER_W'(TIMEOUT_CYCLES - 1);

  ledMode_e          modeReg, modeNext;
  logic [STEP_W-1:0] stepCnt, stepNext;
  logic [TIMER_W-1:0] timerReg, timerNext;
  logic              anyPress;
  logic              stepDue;
  logic              timeoutDue;

  assign anyPress   = |pressPulse;
  assign stepDue    = (stepCnt == STEP_LAST);
  assign timeoutDue = (timerReg == TIMEOUT_LAST);

  always_comb begin
    modeNext  = modeReg;
    stepNext  = stepCnt;
    timerNext = timerReg;
    strobes   = '0;
    strobes.showToggle = (modeReg == MODE_TOGGLE);
    unique case (modeReg)
      MODE_SCROLL: begin
        timerNext = '0;
        if (anyPress) begin
          modeNext = MODE_TOGGLE;
          stepNext = '0;
        end else if (stepDue) begin
          stepNext = '0;
          strobes.stepScroll = 1'b1;
        end else begin
          stepNext = stepCnt + 1'b1;
        end
      end
      MODE_TOGGLE: begin
        stepNext = '0;
        if (anyPress) begin
          timerNext = '0;
          strobes.applyFlips = 1'b1;
        end else if (timeoutDue) begin
          modeNext  = MODE_SCROLL;
          timerNext = '0;
          strobes.restartScroll = 1'b1;
        end else begin
          timerNext = timerReg + 1'b1;
        end
      end
      default: modeNext = MODE_SCROLL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= MODE_SCROLL;
      stepCnt  <= '0;
      timerReg <= '0;
    end else begin
      modeReg  <= modeNext;
      stepCnt  <= stepNext;
      timerReg <= timerNext;
    end
  end

  assign timerVal = timerReg;
  assign inToggle = (modeReg == MODE_TOGGLE);

endmodule

// File: rtl/ledmode_datapath.sv
module ledmode_datapath
  import ledmode_pkg::*;
#(
  parameter int NUM_LEDS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [NUM_LEDS-1:0] pressPulse,
  input  logic                scrollDown,
  input  logic                selExt,
  input  logic [NUM_LEDS-1:0] swBits,
  input  logic [NUM_LEDS-1:0] btnBits,
  output logic [NUM_LEDS-1:0] ledOut,
  output logic [NUM_LEDS-1:0] toggleState
);

  localparam logic [NUM_LEDS-1:0] SCROLL_HOME = NUM_LEDS'(1);

  logic [NUM_LEDS-1:0] scrollReg;
  logic [NUM_LEDS-1:0] scrollUp, scrollDn;
  logic [NUM_LEDS-1:0] toggleReg;

  assign scrollUp = {scrollReg[NUM_LEDS-2:0], scrollReg[NUM_LEDS-1]};
  assign scrollDn = {scrollReg[0], scrollReg[NUM_LEDS-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scrollReg <= SCROLL_HOME;
    end else if (strobes.restartScroll) begin
      scrollReg <= SCROLL_HOME;
    end else if (strobes.stepScroll) begin
      scrollReg <= scrollDown ? scrollDn : scrollUp;
    end
  end

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        toggleReg[i] <= 1'b0;
      end else if (strobes.applyFlips && pressPulse[i]) begin
        toggleReg[i] <= ~toggleReg[i];
      end
    end

    logic internalBit;
    assign internalBit = strobes.showToggle ? toggleReg[i] : scrollReg[i];
    assign ledOut[i]   = selExt ? (swBits[i] ^ btnBits[i]) : internalBit;
  end

  assign toggleState = toggleReg;

endmodule

// File: rtl/ledmode_top.sv
module ledmode_top
  import ledmode_pkg::*;
#(
  parameter int NUM_LEDS       = 4,
  parameter int STEP_CYCLES    = 832_500,
  parameter int TIMEOUT_CYCLES = 16_650_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LEDS-1:0] pressPulse,
  input  logic                scrollDown,
  input  logic                selExt,
  input  logic [NUM_LEDS-1:0] swBits,
  input  logic [NUM_LEDS-1:0] btnBits,
  output logic [NUM_LEDS-1:0] ledOut,
  output logic [NUM_LEDS-1:0] toggleState,
  output logic [3:0]          timerHigh
);

  localparam int TIMER_W = $clog2(TIMEOUT_CYCLES + 1);

  ctrlStrobes_t       strobes;
  logic [TIMER_W-1:0] timerVal;
  logic               inToggleMode;

  ledmode_ctrl #(
    .NUM_LEDS      (NUM_LEDS),
    .STEP_CYCLES   (STEP_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pressPulse(pressPulse),
    .strobes   (strobes),
    .timerVal  (timerVal),
    .inToggle  (inToggleMode)
  );

  ledmode_datapath #(
    .NUM_LEDS(NUM_LEDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pressPulse (pressPulse),
    .scrollDown (scrollDown),
    .selExt     (selExt),
    .swBits     (swBits),
    .btnBits    (btnBits),
    .ledOut     (ledOut),
    .toggleState(toggleState)
  );

  assign timerHigh = timerVal[TIMER_W-1 -: 4];

endmodule

// File: rtl/ledmode_chk.sv
module ledmode_chk #(
  parameter int NUM_LEDS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_LEDS-1:0] pressPulse,
  input logic                selExt,
  input logic [NUM_LEDS-1:0] ledOut,
  input logic [NUM_LEDS-1:0] toggleState,
  input logic [3:0]          timerHigh,
  input logic                inToggle
);

  // R2
  scroll_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inToggle && !selExt) |-> ($countones(ledOut) == 1));

  // R4
  entry_keeps_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inToggle && (|pressPulse)) |=> (inToggle && $stable(toggleState)));

  // R5
  press_flips_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inToggle && (|pressPulse)) |=> (toggleState == ($past(toggleState) ^ $past(pressPulse))));

  // R6
  press_clears_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|pressPulse) |=> (timerHigh == 4'd0));

  // R6
  scroll_timer_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inToggle |-> (timerHigh == 4'd0));

  // R8
  press_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inToggle && (|pressPulse)) |=> inToggle);

endmodule

bind ledmode_top ledmode_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pressPulse (pressPulse),
  .selExt     (selExt),
  .ledOut     (ledOut),
  .toggleState(toggleState),
  .timerHigh  (timerHigh),
  .inToggle   (inToggleMode)
);

// File: tb/ledmode_top_bench.sv
`timescale 1ns/1ps
module ledmode_top_bench;

  localparam int STEP    = 4;
  localparam int TIMEOUT = 40;
  localparam int NVEC    = 8;
  // each entry: {swBits, btnBits, expected ledOut} for R9
  localparam logic [11:0] VEC [NVEC] = '{
    {4'b0000, 4'b0000, 4'b0000},
    {4'b1010, 4'b0000, 4'b1010},
    {4'b0000, 4'b0101, 4'b0101},
    {4'b1111, 4'b0001, 4'b1110},
    {4'b1100, 4'b1010, 4'b0110},
    {4'b0011, 4'b0011, 4'b0000},
    {4'b1111, 4'b1111, 4'b0000},
    {4'b0110, 4'b1001, 4'b1111}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] pressPulse = '0;
  logic       scrollDown = 1'b0;
  logic       selExt = 1'b0;
  logic [3:0] swBits = '0;
  logic [3:0] btnBits = '0;
  logic [3:0] ledOut, toggleState, timerHigh;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  ledmode_top #(
    .NUM_LEDS(4), .STEP_CYCLES(STEP), .TIMEOUT_CYCLES(TIMEOUT)
  ) u_ledmode_top (
    .clk(clk), .rstN(rstN), .pressPulse(pressPulse), .scrollDown(scrollDown),
    .selExt(selExt), .swBits(swBits), .btnBits(btnBits),
    .ledOut(ledOut), .toggleState(toggleState), .timerHigh(timerHigh)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic press(input logic [3:0] bits);
    pressPulse = bits;
    tick(1);
    pressPulse = '0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    tick(3);
    check("R1 led in reset", ledOut, 4'b0001);
    check("R1 toggle in reset", toggleState, 4'b0000);
    check("R1 timer in reset", timerHigh, 4'b0000);
    rstN = 1'b1;
    tick(1);
    check("R1 led after release", ledOut, 4'b0001);
    tick(2);
    check("R2 before first step", ledOut, 4'b0001);
    tick(1);
    check("R2 step up", ledOut, 4'b0010);
    tick(STEP);
    check("R2 step up", ledOut, 4'b0100);
    tick(STEP);
    check("R2 step up", ledOut, 4'b1000);
    tick(STEP);
    check("R2 wrap 3->0", ledOut, 4'b0001);
    scrollDown = 1'b1;
    tick(STEP);
    check("R3 wrap 0->3", ledOut, 4'b1000);
    tick(STEP);
    check("R3 step down", ledOut, 4'b0100);

    // R9 override vector table
    selExt = 1'b1;
    for (int k = 0; k < NVEC; k++) begin
      swBits  = VEC[k][11:8];
      btnBits = VEC[k][7:4];
      #1;
      check("R9 xor override", ledOut, VEC[k][3:0]);
    end
    selExt = 1'b0; swBits = '0; btnBits = '0;
    #1;
    check("R9 internal state back", ledOut, 4'b0100);

    // R4 entry
    press(4'b0100);
    check("R4 entry keeps toggle", toggleState, 4'b0000);
    check("R4 led shows toggle", ledOut, 4'b0000);
    press(4'b0010);
    check("R5 single flip", ledOut, 4'b0010);
    press(4'b1010);
    check("R5 multi flip", toggleState, 4'b1000);
    check("R6 press clears timer", timerHigh, 4'b0000);
    tick(16);
    check("R6 timer high bits", timerHigh, 4'b0100);
    tick(TIMEOUT - 1 - 16);
    check("R7 still toggle before timeout", ledOut, 4'b1000);
    // R8: press exactly on the expiry edge
    press(4'b0001);
    check("R8 flip on expiry edge", toggleState, 4'b1001);
    check("R8 timer restarted", timerHigh, 4'b0000);
    check("R8 still toggle", ledOut, 4'b1001);
    tick(TIMEOUT - 1);
    check("R7 toggle before timeout", ledOut, 4'b1001);
    tick(1);
    check("R7 chase restart", ledOut, 4'b0001);
    check("R7 toggle kept", toggleState, 4'b1001);
    check("R6 timer idle in chase", timerHigh, 4'b0000);
    tick(STEP - 1);
    check("R7 full step period", ledOut, 4'b0001);
    tick(1);
    check("R3 step after restart", ledOut, 4'b1000);

    // R9 override in toggle mode, mode logic keeps running
    press(4'b0001);
    check("R4 entry again", ledOut, 4'b1001);
    selExt = 1'b1; swBits = 4'b0011; btnBits = 4'b0000;
    #1;
    check("R9 override in toggle", ledOut, 4'b0011);
    press(4'b1000);
    check("R9 press under override", toggleState, 4'b0001);
    check("R9 override holds", ledOut, 4'b0011);
    selExt = 1'b0;
    #1;
    check("R9 release shows toggle", ledOut, 4'b0001);

    finishRun();
  end

endmodule